// File: doc/BRIEF.md
# High-Voltage Channel Update Sequencer

This block turns a byte stream, pulled from a host-fed receive FIFO, into timed voltage updates for an array of high-voltage actuator channels. Every update is a two-byte record. The first byte is a header: its upper two bits must be zero, and its lower six bits name a channel. The second byte is the 8-bit voltage code. For each valid record the sequencer performs four steps in order. It writes the code to an 8-bit D/A converter. It waits for the converter to settle. It steers the converter output into one of two sample-and-hold banks through that bank's 5-bit select. It keeps the select steady for the whole acquisition window.

A start pulse opens a packet. The sequencer then drains records until it finds the FIFO empty at a record boundary. At that point it closes the packet with a one-cycle done pulse. If the FIFO runs dry inside a record, the sequencer waits for the missing byte and does not resynchronise. A record that is malformed or names a channel beyond the array is consumed but drives nothing. It raises a one-cycle error pulse instead.

The FIFO is assumed to return data in the cycle after a read request.

Top module: `hvdac_seq`

## Requirements
- R1: While rst_n is low at a clock edge, every registered output returns to zero: busy, done, rec_err, dac_wr, both bank enables and selects, and dac_data. The sequencer goes idle. fifo_sclr is high exactly while rst_n is low, so the FIFO is emptied.
- R2: A start pulse is acted on only while the sequencer is idle. A start pulse seen while a packet is being processed has no effect.
- R3: fifo_rdreq is high only in a cycle where fifo_empty is low. It takes one byte. Two read requests never occur in consecutive cycles.
- R4: The byte read first is the header, with bits 7:6 as prefix and bits 5:0 as channel. The byte read second is the code. dac_wr pulses for one cycle, two cycles after the second byte's read request. dac_data shows the code from that cycle onward.
- R5: After the dac_wr cycle, both bank enables stay low for SETTLE_CYC cycles (default 23). The selected enable rises SETTLE_CYC+1 cycles after the dac_wr cycle.
- R6: Channel bit 5 picks the bank (0 = A, 1 = B). Channel bits 4:0 appear on that bank's select. The other bank's enable stays low, and a disabled bank's select reads 0.
- R7: A bank enable stays high for HOLD_CYC+1 consecutive cycles (default 209). Its select and dac_data do not change during that time.
- R8: A record is discarded if its header prefix is non-zero or its channel is 59 or above. For a discarded record, no dac_wr, no enable, and no change of dac_data occur. rec_err is high for exactly one cycle, two cycles after the code byte's read request.
- R9: If the FIFO is empty after the header byte, the sequencer waits for as long as needed. It then uses the next byte as that record's code.
- R10: busy rises the cycle after the first read request of a packet. The packet ends when the sequencer looks for a header and finds the FIFO empty. busy then falls and done is high for that one cycle. A start with an empty FIFO gives a done pulse without busy.
- R11: When the FIFO holds another byte at the end of a hold window, the next read request is issued in the first cycle after the enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a packet when idle |
| fifo_empty | input | 1 | Receive FIFO holds no byte |
| fifo_q | input | 8 | FIFO read data, valid the cycle after a request |
| fifo_rdreq | output | 1 | FIFO read request |
| fifo_sclr | output | 1 | Synchronous FIFO clear, follows reset |
| dac_data | output | 8 | Voltage code to the D/A |
| dac_wr | output | 1 | D/A load strobe |
| hv_en_a | output | 1 | Bank A hold enable |
| hv_sel_a | output | 5 | Bank A hold channel select |
| hv_en_b | output | 1 | Bank B hold enable |
| hv_sel_b | output | 5 | Bank B hold channel select |
| busy | output | 1 | Packet in progress |
| done | output | 1 | Packet finished pulse |
| rec_err | output | 1 | Discarded-record pulse |

## Verification
Single records go to channels in both banks: channel 5 (A), channel 40 (B) and channel 58, the last valid index. These show that the bank bit and the sub-select are routed apart. Headers with channel 59, channel 63 and a non-zero prefix must be swallowed without touching dac_data. A mixed packet of good and bad records shows that alignment survives a discard and that records run back to back. A header left alone in the FIFO for thirty cycles separates waiting from resynchronising. A second start while busy, a start on an empty FIFO, and a reset in the middle of a hold window cover the packet-boundary and clear paths.

// File: rtl/hvdac_pkg.sv
// Package: hvdac_pkg
// Shared state encoding for the channel update sequencer.
// Assumes: no other content; all widths are set by module parameters.
package hvdac_pkg;

    // Sequencer phases, in the order one record walks through them.
    typedef enum logic [3:0] {
        SEQ_IDLE       = 4'd0,
        SEQ_FETCH_HDR  = 4'd1,
        SEQ_TAKE_HDR   = 4'd2,
        SEQ_FETCH_CODE = 4'd3,
        SEQ_TAKE_CODE  = 4'd4,
        SEQ_LOAD       = 4'd5,
        SEQ_SETTLE     = 4'd6,
        SEQ_SELECT     = 4'd7,
        SEQ_HOLD       = 4'd8
    } seq_state_t;

endpackage

// File: rtl/hvdac_rec_check.sv
// Module: hvdac_rec_check
// Purpose: decodes a record header into a channel index and decides
//          whether the record may drive the outputs.
// Assumes: DATA_W > CH_W; the bits above the channel field form a prefix
//          that must be zero; NUM_CH <= 2**CH_W.
module hvdac_rec_check #(
    parameter int DATA_W = 8,
    parameter int CH_W   = 6,
    parameter int NUM_CH = 59
) (
    input  logic [DATA_W-1:0] hdr,
    output logic [CH_W-1:0]   chan,
    output logic              rec_ok
);
    localparam int PFX_W = DATA_W - CH_W;

    logic prefix_ok;
    logic range_ok;

    // Channel field is the low part of the header.
    assign chan = hdr[CH_W-1:0];

    // Prefix test only exists when the header is wider than the channel field.
    generate
        if (PFX_W > 0) begin : g_prefix
            assign prefix_ok = ~|hdr[DATA_W-1:CH_W];
        end else begin : g_no_prefix
            assign prefix_ok = 1'b1;
        end
    endgenerate

    // Range test is widened by one bit so NUM_CH = 2**CH_W also works.
    assign range_ok = ({1'b0, chan} < (CH_W+1)'(NUM_CH));

    assign rec_ok = prefix_ok && range_ok;

endmodule

// File: rtl/hvdac_wait_timer.sv
// Module: hvdac_wait_timer
// Purpose: one down-counter shared by the settle and hold phases.
// Assumes: the controller loads (length - 1) one cycle before the phase
//          starts; expired is high when the count has reached zero.
module hvdac_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/hvdac_bank_route.sv
// Module: hvdac_bank_route
// Purpose: steers a channel index to one hold bank. The upper channel bits
//          pick the bank; the lower SEL_W bits become that bank's select.
// Assumes: BANK_W >= 1; drive is high only during select and hold phases.
module hvdac_bank_route #(
    parameter int SEL_W  = 5,
    parameter int BANK_W = 1
) (
    input  logic                           drive,
    input  logic [SEL_W+BANK_W-1:0]        chan,
    output logic [(1<<BANK_W)-1:0]         bank_en,
    output logic [(1<<BANK_W)-1:0][SEL_W-1:0] bank_sel
);
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int CH_W      = SEL_W + BANK_W;

    logic [BANK_W-1:0] bank_idx;
    logic [SEL_W-1:0]  sub_sel;

    // Split the channel into bank number and sub-select.
    assign bank_idx = chan[CH_W-1:SEL_W];
    assign sub_sel  = chan[SEL_W-1:0];

    // One enable and one select per bank; idle banks show a zero select.
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign bank_en[b]  = drive && (bank_idx == BANK_W'(b));
            assign bank_sel[b] = bank_en[b] ? sub_sel : '0;
        end
    endgenerate

endmodule

// File: rtl/hvdac_seq_ctrl.sv
// Module: hvdac_seq_ctrl
// Purpose: the record sequencer. Reads header and code bytes, loads the
//          D/A, times the settle and hold phases through the shared timer,
//          and reports busy, done and discarded records.
// Assumes: fifo_q is valid the cycle after fifo_rdreq; SETTLE_CYC and
//          HOLD_CYC are both at least 1 and fit in CNT_W bits.
module hvdac_seq_ctrl
    import hvdac_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CH_W       = 6,
    parameter int CNT_W      = 8,
    parameter int SETTLE_CYC = 23,
    parameter int HOLD_CYC   = 208
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_q,
    input  logic              rec_ok,
    input  logic [CH_W-1:0]   rec_chan,
    input  logic              tmr_expired,
    output logic              fifo_rdreq,
    output logic [DATA_W-1:0] hdr_q,
    output logic [DATA_W-1:0] code_q,
    output logic [CH_W-1:0]   chan_q,
    output logic              dac_wr,
    output logic              drive,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              busy,
    output logic              done,
    output logic              rec_err
);
    localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD   = CNT_W'(HOLD_CYC - 1);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       fetching;

    // A fetch phase requests a byte only when one is present.
    assign fetching   = (state_q == SEQ_FETCH_HDR) || (state_q == SEQ_FETCH_CODE);
    assign fifo_rdreq = fetching && !fifo_empty;

    // Moore strobes derived from the phase.
    assign dac_wr   = (state_q == SEQ_LOAD);
    assign drive    = (state_q == SEQ_SELECT) || (state_q == SEQ_HOLD);
    assign tmr_load = (state_q == SEQ_LOAD) || (state_q == SEQ_SELECT);
    assign tmr_val  = (state_q == SEQ_LOAD) ? SETTLE_LOAD : HOLD_LOAD;

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_IDLE:       if (start) state_d = SEQ_FETCH_HDR;
            SEQ_FETCH_HDR:  state_d = fifo_empty ? SEQ_IDLE : SEQ_TAKE_HDR;
            SEQ_TAKE_HDR:   state_d = SEQ_FETCH_CODE;
            SEQ_FETCH_CODE: if (!fifo_empty) state_d = SEQ_TAKE_CODE;
            SEQ_TAKE_CODE:  state_d = rec_ok ? SEQ_LOAD : SEQ_FETCH_HDR;
            SEQ_LOAD:       state_d = SEQ_SETTLE;
            SEQ_SETTLE:     if (tmr_expired) state_d = SEQ_SELECT;
            SEQ_SELECT:     state_d = SEQ_HOLD;
            SEQ_HOLD:       if (tmr_expired) state_d = SEQ_FETCH_HDR;
            default:        state_d = SEQ_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Record capture: header always, code and channel only for good records.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q  <= '0;
            code_q <= '0;
            chan_q <= '0;
        end else begin
            if (state_q == SEQ_TAKE_HDR) hdr_q <= fifo_q;
            if (state_q == SEQ_TAKE_CODE && rec_ok) begin
                code_q <= fifo_q;
                chan_q <= rec_chan;
            end
        end
    end

    // Packet status flags: busy, done and discard pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            rec_err <= 1'b0;
        end else begin
            done    <= 1'b0;
            rec_err <= (state_q == SEQ_TAKE_CODE) && !rec_ok;
            if (state_q == SEQ_FETCH_HDR) begin
                if (fifo_empty) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    busy <= 1'b1;
                end
            end
        end
    end

    // R3: each request takes one byte; requests never sit back to back.
    assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rdreq |=> !fifo_rdreq);

    // R10: the end-of-packet pulse never coincides with busy.
    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/hvdac_seq.sv
// Module: hvdac_seq
// Purpose: top of the high-voltage channel update sequencer. Ties the
//          record checker, the sequencer, the shared wait timer and the
//          two-bank router together.
// Assumes: a FIFO with registered read data and a synchronous clear; two
//          hold banks, each with a SEL_W-bit select.
module hvdac_seq #(
    parameter int DATA_W     = 8,
    parameter int SEL_W      = 5,
    parameter int NUM_CH     = 59,
    parameter int SETTLE_CYC = 23,
    parameter int HOLD_CYC   = 208
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_q,
    output logic              fifo_rdreq,
    output logic              fifo_sclr,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_wr,
    output logic              hv_en_a,
    output logic [SEL_W-1:0]  hv_sel_a,
    output logic              hv_en_b,
    output logic [SEL_W-1:0]  hv_sel_b,
    output logic              busy,
    output logic              done,
    output logic              rec_err
);
    localparam int BANK_W    = 1;
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int CH_W      = SEL_W + BANK_W;
    localparam int MAX_WAIT  = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
    localparam int CNT_W     = $clog2(MAX_WAIT + 1);
    localparam int RUN_W     = $clog2(HOLD_CYC + 2) + 1;

    logic [DATA_W-1:0] hdr_q;
    logic [DATA_W-1:0] code_q;
    logic [CH_W-1:0]   chan_q;
    logic [CH_W-1:0]   rec_chan;
    logic              rec_ok;
    logic              drive;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic [NUM_BANKS-1:0]            bank_en;
    logic [NUM_BANKS-1:0][SEL_W-1:0] bank_sel;

    // The FIFO is cleared for as long as reset is held.
    assign fifo_sclr = ~rst_n;

    hvdac_rec_check #(
        .DATA_W (DATA_W),
        .CH_W   (CH_W),
        .NUM_CH (NUM_CH)
    ) i_check (
        .hdr    (hdr_q),
        .chan   (rec_chan),
        .rec_ok (rec_ok)
    );

    hvdac_seq_ctrl #(
        .DATA_W     (DATA_W),
        .CH_W       (CH_W),
        .CNT_W      (CNT_W),
        .SETTLE_CYC (SETTLE_CYC),
        .HOLD_CYC   (HOLD_CYC)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .fifo_empty  (fifo_empty),
        .fifo_q      (fifo_q),
        .rec_ok      (rec_ok),
        .rec_chan    (rec_chan),
        .tmr_expired (tmr_expired),
        .fifo_rdreq  (fifo_rdreq),
        .hdr_q       (hdr_q),
        .code_q      (code_q),
        .chan_q      (chan_q),
        .dac_wr      (dac_wr),
        .drive       (drive),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .busy        (busy),
        .done        (done),
        .rec_err     (rec_err)
    );

    hvdac_wait_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    hvdac_bank_route #(
        .SEL_W  (SEL_W),
        .BANK_W (BANK_W)
    ) i_route (
        .drive    (drive),
        .chan     (chan_q),
        .bank_en  (bank_en),
        .bank_sel (bank_sel)
    );

    // Bank 0 is A, bank 1 is B.
    assign dac_data = code_q;
    assign hv_en_a  = bank_en[0];
    assign hv_sel_a = bank_sel[0];
    assign hv_en_b  = bank_en[1];
    assign hv_sel_b = bank_sel[1];

    // Length of the current enable run, used by the hold-window check.
    logic [RUN_W-1:0] en_run_q;
    localparam logic [RUN_W-1:0] HOLD_RUN = RUN_W'(HOLD_CYC + 1);

    // Count consecutive cycles with a bank enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)          en_run_q <= '0;
        else if (|bank_en)   en_run_q <= en_run_q + RUN_W'(1);
        else                 en_run_q <= '0;
    end

    // R5: no bank is enabled in the cycle after the D/A strobe.
    assert_settle_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dac_wr |=> !(hv_en_a || hv_en_b));

    // R6: at most one bank takes the D/A output.
    assert_one_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hv_en_b, hv_en_a}));

    // R7: the code on the D/A does not move while a bank is acquiring.
    assert_code_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_en_a || hv_en_b) |-> $stable(dac_data));

    // R7: an enable run lasts exactly the select cycle plus the hold window.
    assert_hold_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hv_en_a || hv_en_b) && !(hv_en_a || hv_en_b)) |-> (en_run_q == HOLD_RUN));

    // R8: a discarded record leaves the D/A code untouched.
    assert_err_keeps_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_err |-> $stable(dac_data));

endmodule

// File: tb/test_hvdac_seq.sv
// Bench for hvdac_seq: a behavioural FIFO and a cycle-by-cycle reference
// model, compared against the design just before every rising edge.
module test_hvdac_seq;
    localparam int CLK_PERIOD = 20;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int SETTLE_CYC = 23;
    localparam int HOLD_CYC   = 208;
    localparam int NUM_CH     = 59;

    // Reference model phases.
    localparam int M_IDLE = 0, M_F1 = 1, M_C1 = 2, M_F2 = 3, M_C2 = 4,
                   M_LD = 5, M_ST = 6, M_SEL = 7, M_HD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       fifo_empty;
    logic [7:0] fifo_q = 8'h00;
    logic       fifo_rdreq, fifo_sclr, dac_wr, hv_en_a, hv_en_b, busy, done, rec_err;
    logic [7:0] dac_data;
    logic [4:0] hv_sel_a, hv_sel_b;

    logic [7:0] fq[$];
    int         fcnt = 0;
    logic       pop_pend = 1'b0, sclr_pend = 1'b0;

    int tests = 0, fails = 0, cyc = 0;
    int ph = M_IDLE, m_cnt = 0;
    logic [7:0] m_hdr = 8'h00, m_code = 8'h00;
    logic [5:0] m_ch = 6'd0;
    logic m_busy = 1'b0, m_done = 1'b0, m_err = 1'b0;

    int wr_cyc = 0, run = 0, done_cnt = 0, err_cnt = 0, wr_cnt = 0;
    logic en_prev = 1'b0;

    assign fifo_empty = (fcnt == 0);

    always #(HALF) clk = ~clk;

    hvdac_seq #(
        .DATA_W(8), .SEL_W(5), .NUM_CH(NUM_CH),
        .SETTLE_CYC(SETTLE_CYC), .HOLD_CYC(HOLD_CYC)
    ) i_hvdac_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .fifo_empty(fifo_empty),
        .fifo_q(fifo_q), .fifo_rdreq(fifo_rdreq), .fifo_sclr(fifo_sclr),
        .dac_data(dac_data), .dac_wr(dac_wr), .hv_en_a(hv_en_a),
        .hv_sel_a(hv_sel_a), .hv_en_b(hv_en_b), .hv_sel_b(hv_sel_b),
        .busy(busy), .done(done), .rec_err(rec_err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d %s: actual %0h expected %0h", tag, cyc, what, act, exp);
        end
    endtask

    // Compare the design with the model state for the current cycle.
    task automatic compare();
        logic drv, ea, eb;
        drv = (ph == M_SEL) || (ph == M_HD);
        ea  = drv && !m_ch[5];
        eb  = drv && m_ch[5];
        chk("R1", "fifo_sclr", 32'(fifo_sclr), 32'(!rst_n));
        chk("R3", "fifo_rdreq", 32'(fifo_rdreq), 32'(((ph == M_F1) || (ph == M_F2)) && fcnt > 0));
        chk("R4", "dac_wr", 32'(dac_wr), 32'(ph == M_LD));
        chk("R4", "dac_data", 32'(dac_data), 32'(m_code));
        chk("R6", "hv_en_a", 32'(hv_en_a), 32'(ea));
        chk("R6", "hv_en_b", 32'(hv_en_b), 32'(eb));
        chk("R6", "hv_sel_a", 32'(hv_sel_a), ea ? 32'(m_ch[4:0]) : 32'd0);
        chk("R6", "hv_sel_b", 32'(hv_sel_b), eb ? 32'(m_ch[4:0]) : 32'd0);
        chk("R10", "busy", 32'(busy), 32'(m_busy));
        chk("R10", "done", 32'(done), 32'(m_done));
        chk("R8", "rec_err", 32'(rec_err), 32'(m_err));
    endtask

    // Advance the reference model by one clock.
    task automatic model_step();
        if (!rst_n) begin
            ph = M_IDLE; m_busy = 0; m_done = 0; m_err = 0;
            m_code = 8'h00; m_ch = 6'd0; m_hdr = 8'h00; m_cnt = 0;
            return;
        end
        m_done = 0;
        m_err  = 0;
        case (ph)
            M_IDLE: if (start) ph = M_F1;
            M_F1: if (fcnt > 0) begin m_busy = 1; ph = M_C1; end
                  else begin m_busy = 0; m_done = 1; ph = M_IDLE; end
            M_C1: begin m_hdr = fifo_q; ph = M_F2; end
            M_F2: if (fcnt > 0) ph = M_C2;
            M_C2: if (m_hdr[7:6] != 2'b00 || int'(m_hdr[5:0]) >= NUM_CH) begin
                      m_err = 1; ph = M_F1;
                  end else begin
                      m_ch = m_hdr[5:0]; m_code = fifo_q; ph = M_LD;
                  end
            M_LD: begin m_cnt = SETTLE_CYC; ph = M_ST; end
            M_ST: begin m_cnt--; if (m_cnt == 0) ph = M_SEL; end
            M_SEL: begin m_cnt = HOLD_CYC; ph = M_HD; end
            M_HD: begin m_cnt--; if (m_cnt == 0) ph = M_F1; end
            default: ph = M_IDLE;
        endcase
    endtask

    // Just before each rising edge: compare, record FIFO actions, watch timing.
    always @(negedge clk) begin
        logic en_now;
        #(HALF - 2);
        cyc++;
        if (cyc > 1) compare();
        sclr_pend = fifo_sclr;
        pop_pend  = fifo_rdreq;
        en_now = hv_en_a || hv_en_b;
        if (dac_wr) begin wr_cyc = cyc; wr_cnt++; end
        if (done) done_cnt++;
        if (rec_err) err_cnt++;
        if (en_now && !en_prev) begin
            chk("R5", "settle gap", 32'(cyc - wr_cyc), 32'(SETTLE_CYC + 1));
            run = 0;
        end
        if (en_now) run++;
        if (!en_now && en_prev && rst_n) begin
            chk("R7", "enable run", 32'(run), 32'(HOLD_CYC + 1));
            if (fcnt > 0) chk("R11", "next read after hold", 32'(fifo_rdreq), 32'd1);
        end
        en_prev = en_now;
        model_step();
    end

    // Behavioural FIFO: acts just after the edge the design sampled.
    always @(posedge clk) begin
        #1;
        if (sclr_pend) begin
            fq.delete();
            fcnt = 0;
        end else if (pop_pend && fcnt > 0) begin
            fifo_q = fq.pop_front();
            fcnt = fcnt - 1;
        end
    end

    task automatic push(input logic [7:0] b);
        fq.push_back(b);
        fcnt = fcnt + 1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (ph != M_IDLE);
        repeat (2) @(negedge clk);
    endtask

    task automatic one_record(input string tag, input logic [7:0] h, input logic [7:0] c,
                              input int exp_wr, input int exp_err, input logic [7:0] exp_data);
        int w0, e0;
        w0 = wr_cnt; e0 = err_cnt;
        @(negedge clk); push(h); push(c);
        pulse_start();
        wait_idle();
        chk(tag, "writes", 32'(wr_cnt - w0), 32'(exp_wr));
        chk(tag, "errors", 32'(err_cnt - e0), 32'(exp_err));
        chk(tag, "dac_data", 32'(dac_data), 32'(exp_data));
    endtask

    initial begin
        int d0, w0;
        repeat (4) @(negedge clk);
        chk("R1", "busy in reset", 32'(busy), 32'd0);
        chk("R1", "dac_data in reset", 32'(dac_data), 32'd0);
        chk("R1", "enables in reset", 32'({hv_en_a, hv_en_b}), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        one_record("R6", 8'h05, 8'hA5, 1, 0, 8'hA5);     // bank A, select 5
        one_record("R6", 8'h28, 8'h3C, 1, 0, 8'h3C);     // bank B, select 8
        one_record("R4", 8'h3A, 8'hFF, 1, 0, 8'hFF);     // channel 58, last valid
        one_record("R8", 8'h3B, 8'h11, 0, 1, 8'hFF);     // channel 59 rejected
        one_record("R8", 8'h3F, 8'h22, 0, 1, 8'hFF);     // channel 63 rejected
        one_record("R8", 8'h45, 8'h33, 0, 1, 8'hFF);     // prefix 01 rejected

        // Mixed packet, records back to back (R11, R10).
        d0 = done_cnt; w0 = wr_cnt;
        @(negedge clk);
        push(8'h01); push(8'h10);
        push(8'h80); push(8'h99);
        push(8'h21); push(8'h20);
        push(8'h1F); push(8'h30);
        pulse_start();
        wait_idle();
        chk("R11", "writes in packet", 32'(wr_cnt - w0), 32'd3);
        chk("R10", "done pulses", 32'(done_cnt - d0), 32'd1);
        chk("R11", "last code", 32'(dac_data), 32'h30);

        // Header alone for a while, then its code (R9).
        w0 = wr_cnt;
        @(negedge clk); push(8'h11);
        pulse_start();
        repeat (30) @(negedge clk);
        chk("R9", "waits without write", 32'(wr_cnt - w0), 32'd0);
        push(8'h5A);
        wait_idle();
        chk("R9", "code after gap", 32'(dac_data), 32'h5A);
        chk("R9", "one write", 32'(wr_cnt - w0), 32'd1);

        // Start during a packet is ignored (R2).
        d0 = done_cnt;
        @(negedge clk); push(8'h02); push(8'h77);
        pulse_start();
        repeat (50) @(negedge clk);
        pulse_start();
        wait_idle();
        chk("R2", "done pulses", 32'(done_cnt - d0), 32'd1);
        chk("R2", "code", 32'(dac_data), 32'h77);

        // Start with nothing queued (R10).
        d0 = done_cnt;
        pulse_start();
        wait_idle();
        chk("R10", "empty packet done", 32'(done_cnt - d0), 32'd1);

        // Reset during a hold window clears the FIFO (R1).
        @(negedge clk); push(8'h03); push(8'h44); push(8'h04); push(8'h55);
        pulse_start();
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "fifo cleared", 32'(fcnt), 32'd0);
        chk("R1", "dac_data cleared", 32'(dac_data), 32'd0);
        chk("R1", "busy cleared", 32'(busy), 32'd0);
        rst_n = 1'b1;
        w0 = wr_cnt;
        pulse_start();
        wait_idle();
        chk("R1", "no stale writes", 32'(wr_cnt - w0), 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule